// File: doc/BRIEF.md
# Vectorised Instruction Expander

This block turns one decoded three-operand register instruction into a run of scalar micro-operations. Each architectural register carries a "vector" tag and a length in a table that the surrounding decoder holds. When an instruction is accepted, every operand whose register is tagged is stepped by one register number per element. Operands that are not tagged keep their register number in every element. The opcode is copied unchanged into each element. The number of elements comes from the vector-length input. No new opcodes are involved: parallel work is implied entirely by the register tags.

The instruction enters on a valid/ready handshake. The block samples the operands, the tag table, the length table and the vector length only at the accepting clock edge. It then drives micro-operations, one per cycle, on a valid/ready output stream that feeds an issue FIFO. Output ready is the FIFO's not-full signal. While a micro-operation is offered and output ready is low, the offered fields hold still.

Illegal combinations are caught at acceptance. In that case a one-cycle exception pulse carries a code, and no micro-operation is issued. The illegal combinations are: a jump-and-link-register with a tagged operand, tagged sources of unequal length, a tagged destination shorter than its tagged source, and an element that would step past the last register.

Top module: `vx_expander`

## Requirements
- R1: `in_ready` is high exactly when no micro-operation of an earlier instruction is still to be issued and `out_ready` is high. An instruction is taken at a rising edge where `in_valid` and `in_ready` are both high.
- R2: A legal instruction with at least one tagged source and `vl` ≥ 1 issues exactly `vl` micro-operations. `out_valid` first rises in the cycle after acceptance, and while `out_ready` stays high one micro-operation transfers per cycle.
- R3: In element i (counting from 0), a tagged operand (rd, rs1 or rs2) carries its base register number plus i. A register is tagged when bit r of `vec_tag` is 1.
- R4: An untagged operand carries the same register number in every element, and `out_op` equals the accepted opcode in every element.
- R5: When neither source is tagged and `vl` ≥ 1, exactly one micro-operation is issued with rd, rs1 and rs2 unchanged, even if rd is tagged.
- R6: A legal instruction with `vl` = 0 issues nothing and raises no exception, and `in_ready` is high again in the next cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and all `out_*` fields hold their values.
- R8: An illegal instruction issues nothing. `exc_valid` is high for exactly the one cycle after acceptance, with `exc_code` giving the cause: 1 jump, 2 source length mismatch, 3 destination too short, 4 register range. When several causes apply, the smallest code is reported.
- R9: Code 1: the opcode equals parameter `JUMP_OP` (default 7'h67) and any of rd, rs1 or rs2 is tagged.
- R10: Code 2: both sources are tagged and their lengths differ. The length of register r is `vec_len[r*LENW +: LENW]`.
- R11: Code 3: rd is tagged, at least one source is tagged, and the tagged source's length is greater than rd's length. An equal length is legal.
- R12: Code 4: a tagged operand with base b would reach b + n − 1 > NREG − 1, where n is the element count. Reaching exactly NREG − 1 is legal, and register numbers never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_rd | input | REGW | Destination register |
| in_rs1 | input | REGW | First source register |
| in_rs2 | input | REGW | Second source register |
| in_op | input | OPW | Opcode |
| in_vl | input | VLW | Vector length (element count) |
| vec_tag | input | NREG | Bit r set: register r is a vector |
| vec_len | input | NREG*LENW | Per-register vector length table |
| out_valid | output | 1 | Micro-operation offered |
| out_ready | input | 1 | Issue FIFO not full |
| out_rd | output | REGW | Micro-operation destination |
| out_rs1 | output | REGW | Micro-operation first source |
| out_rs2 | output | REGW | Micro-operation second source |
| out_op | output | OPW | Micro-operation opcode |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_code | output | 3 | Exception cause |

## Verification
The bench builds the block with its defaults: 32 registers, 6-bit lengths and vector lengths, and 7-bit opcodes. With these values a run can be driven that ends exactly on register 31, and a run one register longer must be refused. Long runs with mixed tagged and fixed operands are issued under a repeating `out_ready` stall pattern, so that field holding and the gating of `in_ready` are both exercised. Instructions that meet several illegal conditions at once check the order in which the causes are ranked.

// File: rtl/vx_pkg.sv
package vx_pkg;

  typedef enum logic [2:0] {
    EXC_NONE   = 3'd0,
    EXC_JUMP   = 3'd1,
    EXC_SRCLEN = 3'd2,
    EXC_DSTLEN = 3'd3,
    EXC_RANGE  = 3'd4
  } exc_e;

endpackage

// File: rtl/vx_check.sv
module vx_check
  import vx_pkg::*;
#(
  parameter int NREG = 32,
  parameter int LENW = 6,
  parameter int VLW = 6,
  parameter int OPW = 7,
  parameter logic [OPW-1:0] JUMP_OP = 7'h67,
  localparam int REGW = $clog2(NREG),
  localparam int SW = REGW + VLW + 1
) (
  input  logic [REGW-1:0]      rd,
  input  logic [REGW-1:0]      rs1,
  input  logic [REGW-1:0]      rs2,
  input  logic [OPW-1:0]       op,
  input  logic [NREG-1:0]      tags,
  input  logic [NREG*LENW-1:0] lens,
  input  logic [VLW-1:0]       vl,
  output exc_e                 exc,
  output logic [VLW-1:0]       count,
  output logic                 tag_d,
  output logic                 tag_1,
  output logic                 tag_2
);

  logic [LENW-1:0] len_a [NREG];

  // unpack the per-register length table
  for (genvar g = 0; g < NREG; g++) begin : g_len
    assign len_a[g] = lens[g*LENW +: LENW];
  end

  logic [LENW-1:0] len_1, len_2, len_d, src_len;
  logic            is_jump, src_mismatch, dst_short, out_of_range;
  logic [REGW-1:0] base_a [3];
  logic            tg_a   [3];

  always_comb begin
    tag_d   = tags[rd];
    tag_1   = tags[rs1];
    tag_2   = tags[rs2];
    len_d   = len_a[rd];
    len_1   = len_a[rs1];
    len_2   = len_a[rs2];
    src_len = tag_1 ? len_1 : len_2;

    if (vl == '0)               count = '0;
    else if (tag_1 || tag_2)    count = vl;
    else                        count = VLW'(1);

    is_jump      = (op == JUMP_OP) && (tag_d || tag_1 || tag_2);
    src_mismatch = tag_1 && tag_2 && (len_1 != len_2);
    dst_short    = tag_d && (tag_1 || tag_2) && (src_len > len_d);

    base_a[0] = rd;  tg_a[0] = tag_d;
    base_a[1] = rs1; tg_a[1] = tag_1;
    base_a[2] = rs2; tg_a[2] = tag_2;
    out_of_range = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (tg_a[k] && (count != '0) &&
          ((SW'(base_a[k]) + SW'(count) - SW'(1)) > SW'(NREG - 1)))
        out_of_range = 1'b1;
    end

    // smallest code wins
    if (is_jump)           exc = EXC_JUMP;
    else if (src_mismatch) exc = EXC_SRCLEN;
    else if (dst_short)    exc = EXC_DSTLEN;
    else if (out_of_range) exc = EXC_RANGE;
    else                   exc = EXC_NONE;
  end

endmodule

// File: rtl/vx_sequencer.sv
module vx_sequencer #(
  parameter int NREG = 32,
  parameter int VLW = 6,
  parameter int OPW = 7,
  localparam int REGW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [REGW-1:0] rd,
  input  logic [REGW-1:0] rs1,
  input  logic [REGW-1:0] rs2,
  input  logic [OPW-1:0]  op,
  input  logic            tag_d,
  input  logic            tag_1,
  input  logic            tag_2,
  input  logic [VLW-1:0]  count,
  input  logic            out_ready,
  output logic            busy,
  output logic [REGW-1:0] out_rd,
  output logic [REGW-1:0] out_rs1,
  output logic [REGW-1:0] out_rs2,
  output logic [OPW-1:0]  out_op
);

  logic [REGW-1:0] b_rd, b_rs1, b_rs2;
  logic [OPW-1:0]  op_q;
  logic            td_q, t1_q, t2_q;
  logic [REGW-1:0] idx, last;
  logic            at_last;

  assign at_last = (idx == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      last  <= '0;
      b_rd  <= '0;
      b_rs1 <= '0;
      b_rs2 <= '0;
      op_q  <= '0;
      td_q  <= 1'b0;
      t1_q  <= 1'b0;
      t2_q  <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= '0;
      // range check guarantees count-1 fits a register number
      last  <= REGW'(count - VLW'(1));
      b_rd  <= rd;
      b_rs1 <= rs1;
      b_rs2 <= rs2;
      op_q  <= op;
      td_q  <= tag_d;
      t1_q  <= tag_1;
      t2_q  <= tag_2;
    end else if (busy && out_ready) begin
      if (at_last) busy <= 1'b0;
      else         idx  <= idx + REGW'(1);
    end
  end

  assign out_rd  = td_q ? b_rd  + idx : b_rd;
  assign out_rs1 = t1_q ? b_rs1 + idx : b_rs1;
  assign out_rs2 = t2_q ? b_rs2 + idx : b_rs2;
  assign out_op  = op_q;

  // R7: a stalled offer holds still
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_ready) |=> (busy && $stable(out_rd) && $stable(out_rs1)
                              && $stable(out_rs2) && $stable(out_op)));

  // R2: a non-final transfer is followed by another offer of the same opcode
  a_r2_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_ready && !at_last) |=> (busy && $stable(out_op)));

  // R3: a tagged destination advances by one per transfer
  a_r3_rd_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_ready && !at_last && td_q) |=> (out_rd == $past(out_rd) + REGW'(1)));

  // R4: an untagged first source stays fixed across transfers
  a_r4_rs1_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_ready && !at_last && !t1_q) |=> (out_rs1 == $past(out_rs1)));

endmodule

// File: rtl/vx_expander.sv
module vx_expander
  import vx_pkg::*;
#(
  parameter int NREG = 32,
  parameter int LENW = 6,
  parameter int VLW = 6,
  parameter int OPW = 7,
  parameter logic [OPW-1:0] JUMP_OP = 7'h67,
  localparam int REGW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [REGW-1:0]      in_rd,
  input  logic [REGW-1:0]      in_rs1,
  input  logic [REGW-1:0]      in_rs2,
  input  logic [OPW-1:0]       in_op,
  input  logic [VLW-1:0]       in_vl,
  input  logic [NREG-1:0]      vec_tag,
  input  logic [NREG*LENW-1:0] vec_len,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [REGW-1:0]      out_rd,
  output logic [REGW-1:0]      out_rs1,
  output logic [REGW-1:0]      out_rs2,
  output logic [OPW-1:0]       out_op,
  output logic                 exc_valid,
  output logic [2:0]           exc_code
);

  exc_e            chk_exc;
  logic [VLW-1:0]  chk_count;
  logic            chk_td, chk_t1, chk_t2;
  logic            busy, accept, start;

  vx_check #(
    .NREG(NREG), .LENW(LENW), .VLW(VLW), .OPW(OPW), .JUMP_OP(JUMP_OP)
  ) u_check (
    .rd(in_rd), .rs1(in_rs1), .rs2(in_rs2), .op(in_op),
    .tags(vec_tag), .lens(vec_len), .vl(in_vl),
    .exc(chk_exc), .count(chk_count),
    .tag_d(chk_td), .tag_1(chk_t1), .tag_2(chk_t2)
  );

  assign in_ready = !busy && out_ready;
  assign accept   = in_valid && in_ready;
  assign start    = accept && (chk_exc == EXC_NONE) && (chk_count != '0);

  vx_sequencer #(
    .NREG(NREG), .VLW(VLW), .OPW(OPW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd(in_rd), .rs1(in_rs1), .rs2(in_rs2), .op(in_op),
    .tag_d(chk_td), .tag_1(chk_t1), .tag_2(chk_t2),
    .count(chk_count), .out_ready(out_ready),
    .busy(busy),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_op(out_op)
  );

  assign out_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_code  <= 3'd0;
    end else begin
      exc_valid <= accept && (chk_exc != EXC_NONE);
      exc_code  <= (accept && (chk_exc != EXC_NONE)) ? 3'(chk_exc) : 3'd0;
    end
  end

  // R8: an exception pulse never coincides with an issued element
  a_r8_exc_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !out_valid);

  // R8: the pulse lasts one cycle when no new instruction arrives
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !in_valid) |=> !exc_valid);

  // R1: an instruction is only taken with no run pending
  a_r1_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !out_valid);

  // R6: an empty-length instruction leaves the block idle
  a_r6_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_vl == '0) |=> (!out_valid && !exc_valid
      || exc_valid));

endmodule

// File: tb/vx_expander_tb_top.sv
module vx_expander_tb_top;

  localparam int NREG = 32;
  localparam int LENW = 6;
  localparam int VLW  = 6;
  localparam int OPW  = 7;
  localparam int REGW = 5;
  localparam logic [OPW-1:0] JOP = 7'h67;
  localparam logic [OPW-1:0] ADD = 7'h33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [REGW-1:0]      in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [OPW-1:0]       in_op = '0;
  logic [VLW-1:0]       in_vl = '0;
  logic [NREG-1:0]      vec_tag = '0;
  logic [NREG*LENW-1:0] vec_len = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic [REGW-1:0]      out_rd, out_rs1, out_rs2;
  logic [OPW-1:0]       out_op;
  logic                 exc_valid;
  logic [2:0]           exc_code;

  vx_expander dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_op(in_op), .in_vl(in_vl),
    .vec_tag(vec_tag), .vec_len(vec_len),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_op(out_op),
    .exc_valid(exc_valid), .exc_code(exc_code)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  logic [21:0] exp_q[$];
  int          exc_q[$];

  // back-pressure pattern: stall every third cycle when enabled
  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= !bp_on || (cyc % 3 != 0);
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 20000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      // R1: ready only with no run pending and downstream ready
      n_cmp++;
      if (in_ready !== ((exp_q.size() == 0) && out_ready)) begin
        n_bad++;
        $display("FAIL R1 in_ready actual %0b expected %0b", in_ready,
                 (exp_q.size() == 0) && out_ready);
      end
      // R2: an offer exists exactly while elements are outstanding
      n_cmp++;
      if (out_valid !== (exp_q.size() != 0)) begin
        n_bad++;
        $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, exp_q.size() != 0);
      end
      // R3 R4 R5 fields; R7 holds because the head is only popped on transfer
      if (out_valid && exp_q.size() != 0) begin
        n_cmp++;
        if ({out_rd, out_rs1, out_rs2, out_op} !== exp_q[0]) begin
          n_bad++;
          $display("FAIL R3/R4/R5/R7 element actual %h expected %h",
                   {out_rd, out_rs1, out_rs2, out_op}, exp_q[0]);
        end
        if (out_ready) void'(exp_q.pop_front());
      end
      // R8 exception pulse and code
      n_cmp++;
      if (exc_valid !== (exc_q.size() != 0)) begin
        n_bad++;
        $display("FAIL R8 exc_valid actual %0b expected %0b", exc_valid, exc_q.size() != 0);
      end else if (exc_valid) begin
        n_cmp++;
        if (int'(exc_code) != exc_q[0]) begin
          n_bad++;
          $display("FAIL R8/R9/R10/R11/R12 exc_code actual %0d expected %0d",
                   exc_code, exc_q[0]);
        end
      end
      if (exc_q.size() != 0) void'(exc_q.pop_front());
    end
  end

  function automatic int len_of(int r);
    return int'(vec_len[r*LENW +: LENW]);
  endfunction

  task automatic set_len(int r, int l);
    vec_len[r*LENW +: LENW] = LENW'(l);
  endtask

  // reference model: expected outcome of one accepted instruction
  task automatic model(int rd, int r1, int r2, int op, int vl);
    bit vd = vec_tag[rd];
    bit v1 = vec_tag[r1];
    bit v2 = vec_tag[r2];
    int n = (vl == 0) ? 0 : ((v1 || v2) ? vl : 1);
    int code = 0;
    int slen = v1 ? len_of(r1) : len_of(r2);
    bit rng = 0;
    if (n > 0) begin
      if (vd && rd + n - 1 > NREG - 1) rng = 1;
      if (v1 && r1 + n - 1 > NREG - 1) rng = 1;
      if (v2 && r2 + n - 1 > NREG - 1) rng = 1;
    end
    if (op == int'(JOP) && (vd || v1 || v2))             code = 1;  // R9
    else if (v1 && v2 && len_of(r1) != len_of(r2))       code = 2;  // R10
    else if (vd && (v1 || v2) && slen > len_of(rd))      code = 3;  // R11
    else if (rng)                                        code = 4;  // R12
    if (code != 0) exc_q.push_back(code);
    else begin
      for (int i = 0; i < n; i++)
        exp_q.push_back({REGW'(vd ? rd + i : rd), REGW'(v1 ? r1 + i : r1),
                         REGW'(v2 ? r2 + i : r2), OPW'(op)});
    end
  endtask

  task automatic send(int rd, int r1, int r2, int op, int vl);
    @(negedge clk);
    in_valid = 1'b1;
    in_rd = REGW'(rd); in_rs1 = REGW'(r1); in_rs2 = REGW'(r2);
    in_op = OPW'(op);  in_vl = VLW'(vl);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    model(rd, r1, r2, op, vl);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || exc_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) set_len(r, 8);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // reset state (R1, R2, R8)
    n_cmp++;
    if (out_valid !== 1'b0 || exc_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset state actual v%0b e%0b r%0b expected 0 0 1",
               out_valid, exc_valid, in_ready);
    end

    // R3 R4: mixed tagged/fixed operands, 7/4/1 -> 8/4/2 -> 9/4/3
    vec_tag[7] = 1; vec_tag[1] = 1;
    send(7, 4, 1, ADD, 3);
    drain();
    // R5: untagged sources, one element even with tagged rd
    send(10, 11, 12, ADD, 5);
    send(7, 11, 12, ADD, 4);
    vec_tag[31] = 1;
    send(31, 11, 12, ADD, 10);
    drain();
    // R6: empty length
    send(7, 4, 1, ADD, 0);
    drain();
    // R9: jump with tag, also mismatched (priority)
    vec_tag[20] = 1; set_len(1, 3); set_len(20, 5);
    send(2, 1, 20, JOP, 2);
    send(5, 4, 1, JOP, 2);
    // R10: source length mismatch
    send(3, 1, 20, ADD, 2);
    drain();
    // R11: destination too short, then equal length legal
    set_len(7, 2);
    send(7, 1, 4, ADD, 2);
    set_len(7, 3);
    send(7, 1, 4, ADD, 2);
    drain();
    for (int r = 0; r < NREG; r++) set_len(r, 8);
    // R12: range, just past and exactly at the last register
    vec_tag[30] = 1; vec_tag[29] = 1;
    send(5, 30, 6, ADD, 3);
    send(5, 29, 6, ADD, 3);
    vec_tag[28] = 1; vec_tag[2] = 1;
    send(28, 2, 6, ADD, 5);
    drain();
    // R2 R7: long runs under back-pressure, back to back
    bp_on = 1'b1;
    vec_tag[16] = 1; vec_tag[24] = 1;
    send(16, 3, 24, ADD, 8);
    send(16, 24, 5, 7'h13, 8);
    send(20, 2, 9, ADD, 6);
    drain();
    bp_on = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule